// File: doc/BRIEF.md
# Synthesizer Programming Register Loader

This block is the write side of a two-wire serial slave for a frequency-synthesizer control bank. It receives clock and data line samples that are already synchronous to the system clock. From them it detects bus start and stop conditions, collects the address byte and the data bytes, and pulls the data line low to acknowledge. Data bytes go into a five-entry map through a pointer that advances after each byte. The map holds two divider bytes followed by three control bytes.

The two kinds of byte take effect at different times. Control bytes update their outputs as soon as the eighth clock pulse of the byte has ended. Divider bytes are held in staging registers. They are handed downstream as a single 15-bit word at the stop condition, and only when both divider bytes arrived in the same transmission. A handoff opens a computation window of a set number of system clocks. A start condition inside that window cancels the handoff, and the divider and ratio outputs return to their previous values.

Byte engine states: `BUS_IDLE`, `BUS_ADDR`, `BUS_ADDR_ACK`, `BUS_DATA`, `BUS_DATA_ACK`, `BUS_IGNORE`.

Byte engine transitions:
- A start condition moves any state to `BUS_ADDR`.
- A stop condition moves any state to `BUS_IDLE`.
- `BUS_ADDR` goes to `BUS_ADDR_ACK` after eight bits when the address matches and the direction bit is write. Otherwise it goes to `BUS_IGNORE`.
- `BUS_ADDR_ACK` goes to `BUS_DATA` on the falling edge of the ninth clock.
- `BUS_DATA` goes to `BUS_DATA_ACK` after eight bits and emits the byte.
- `BUS_DATA_ACK` goes to `BUS_DATA` on the falling edge of the ninth clock.

Commit engine states: `CM_READY` and `CM_COMPUTE`.
- A commit request moves `CM_READY` to `CM_COMPUTE`.
- `CM_COMPUTE` returns to `CM_READY` when the window count runs out, or on a start condition, which aborts the handoff.

Top module: `i2c_synth_loader`

## Requirements
- R1: The slave address is 7 bits: the five bits of parameter `ADDR_BASE` (default 5'b11000) followed by the 2-bit `addr_sel_i`. The eighth bit is the direction bit, and 0 means write. A matching write address is acknowledged by pulling SDA low during the ninth clock. On a mismatch or a direction bit of 1, the slave gives no acknowledge and ignores every byte until the next start.
- R2: Every data byte of an addressed write is acknowledged, including bytes past the end of the map.
- R3: Bit 7 of the first data byte after a start selects the entry point. A value of 0 enters at the divider high byte (index 0). A value of 1 enters at control byte 0 (index 2).
- R4: The pointer advances one entry per byte in the order divider high (bits 14:8 taken from byte bits 6:0), divider low (bits 7:0), control 0, control 1, control 2. Bytes beyond index 4 are discarded.
- R5: A control byte appears on its output once its eighth SCL pulse has ended, before any stop condition.
- R6: Divider bytes do not change `div_word_o` before the stop condition. At the stop condition, a transmission that held both divider bytes updates `div_word_o` and pulses `div_load_o` for one cycle.
- R7: A transmission that carries only one divider byte leaves `div_word_o` unchanged and gives no load pulse.
- R8: The ratio field, bits 2:0 of control byte 0, is staged. It reaches `ratio_o` only together with a divider commit.
- R9: `busy_o` rises with the load pulse and stays high for `COMP_CYCLES` system clocks.
- R10: A start condition while `busy_o` is high restores the previous `div_word_o` and `ratio_o`, pulses `div_abort_o` for one cycle and clears `busy_o`.
- R11: A repeated start resets the pointer, the entry-point decision and the record of which divider bytes have arrived.
- R12: After reset, all register outputs are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| addr_sel_i | input | 2 | Selects one of four slave addresses |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| div_word_o | output | 15 | Committed divider word |
| ratio_o | output | 3 | Committed ratio-select field |
| ctrl0_o | output | 8 | Control byte 0 |
| ctrl1_o | output | 8 | Control byte 1 |
| ctrl2_o | output | 8 | Control byte 2 |
| div_load_o | output | 1 | One-cycle pulse when a divider word is handed downstream |
| div_abort_o | output | 1 | One-cycle pulse when a pending handoff is cancelled |
| busy_o | output | 1 | High during the computation window |

## Verification
The main function is driven with transmission patterns that each isolate one behaviour:
- Full five-byte writes tie each byte to its map position.
- Control-only writes show that the entry bit skips the divider.
- Divider-only writes show that the ratio is held back unless the divider pair commits.
- Single-divider-byte writes separate pairing from simple arrival.
- Over-long writes confirm that extra bytes are discarded while still being acknowledged.
- Wrong-address and read-direction transfers confirm the slave stays silent.

Directed sequences then cover the remaining rules:
- Reading outputs in the middle of a transmission separates the per-byte control update from the divider update held until the stop condition.
- A start placed inside the computation window, and another placed after it, separate abort from normal completion.
- A repeated start between two divider bytes confirms that pairing restarts.

// File: rtl/i2c_ldr_pkg.sv
package i2c_ldr_pkg;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_ADDR_ACK,
        BUS_DATA,
        BUS_DATA_ACK,
        BUS_IGNORE
    } bus_state_e;

    typedef enum logic {
        CM_READY,
        CM_COMPUTE
    } commit_state_e;

    localparam int MAP_BYTES  = 5;
    localparam int CTRL_BASE  = 2;
    localparam int CTRL_BYTES = MAP_BYTES - CTRL_BASE;

endpackage

// File: rtl/i2c_ldr_edges.sv
module i2c_ldr_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2c_ldr_byte_fsm.sv
module i2c_ldr_byte_fsm
    import i2c_ldr_pkg::*;
#(
    parameter int         BASE_W    = 5,
    parameter logic [4:0] ADDR_BASE = 5'b11000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] addr_sel_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    output logic       byte_stb_o,
    output logic [7:0] byte_data_o,
    output logic       sda_pull_o
);
    localparam int CNT_W = 4;

    bus_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
    logic [7:0]        shreg_q, shreg_d;
    logic              stb_d;
    logic              addr_hit;

    assign addr_hit = (shreg_q[7:1] == {ADDR_BASE[BASE_W-1:0], addr_sel_i}) && !shreg_q[0];

    // state register and next-state logic
    always_comb begin
        state_d  = state_q;
        bitcnt_d = bitcnt_q;
        shreg_d  = shreg_q;
        stb_d    = 1'b0;
        if (start_i) begin
            state_d  = BUS_ADDR;
            bitcnt_d = '0;
        end else if (stop_i) begin
            state_d = BUS_IDLE;
        end else begin
            unique case (state_q)
                BUS_IDLE, BUS_IGNORE: begin
                end
                BUS_ADDR: begin
                    if (scl_rise_i) begin
                        shreg_d  = {shreg_q[6:0], sda_i};
                        bitcnt_d = bitcnt_q + CNT_W'(1);
                    end else if (scl_fall_i && bitcnt_q == CNT_W'(8)) begin
                        state_d = addr_hit ? BUS_ADDR_ACK : BUS_IGNORE;
                    end
                end
                BUS_ADDR_ACK, BUS_DATA_ACK: begin
                    if (scl_fall_i) begin
                        state_d  = BUS_DATA;
                        bitcnt_d = '0;
                    end
                end
                BUS_DATA: begin
                    if (scl_rise_i) begin
                        shreg_d  = {shreg_q[6:0], sda_i};
                        bitcnt_d = bitcnt_q + CNT_W'(1);
                    end else if (scl_fall_i && bitcnt_q == CNT_W'(8)) begin
                        stb_d   = 1'b1;
                        state_d = BUS_DATA_ACK;
                    end
                end
                default: state_d = BUS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= BUS_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
        end else begin
            state_q  <= state_d;
            bitcnt_q <= bitcnt_d;
            shreg_q  <= shreg_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_o <= 1'b0;
            byte_stb_o <= 1'b0;
        end else begin
            sda_pull_o <= (state_d == BUS_ADDR_ACK) || (state_d == BUS_DATA_ACK);
            byte_stb_o <= stb_d;
        end
    end

    assign byte_data_o = shreg_q;

    // R1
    ack_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);

    // R1
    ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_IGNORE) |-> !sda_pull_o);

endmodule

// File: rtl/i2c_ldr_reg_map.sv
module i2c_ldr_reg_map
    import i2c_ldr_pkg::*;
#(
    parameter int DIV_W   = 15,
    parameter int RATIO_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      stop_i,
    input  logic                      byte_stb_i,
    input  logic [7:0]                byte_data_i,
    input  logic [RATIO_W-1:0]        ratio_cur_i,
    output logic [CTRL_BYTES*8-1:0]   ctrl_flat_o,
    output logic                      commit_req_o,
    output logic [DIV_W-1:0]          stg_div_o,
    output logic [RATIO_W-1:0]        stg_ratio_o
);
    localparam int PTR_W = $clog2(MAP_BYTES + 1);
    localparam int HI_W  = DIV_W - 8;

    logic [PTR_W-1:0]   ptr_q;
    logic [PTR_W-1:0]   idx;
    logic               first_q;
    logic               got_hi_q, got_lo_q;
    logic [HI_W-1:0]    hi_q;
    logic [7:0]         lo_q;
    logic [RATIO_W-1:0] stg_ratio_q;

    always_comb begin
        if (first_q)
            idx = byte_data_i[7] ? PTR_W'(CTRL_BASE) : '0;
        else
            idx = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            first_q     <= 1'b1;
            got_hi_q    <= 1'b0;
            got_lo_q    <= 1'b0;
            hi_q        <= '0;
            lo_q        <= '0;
            stg_ratio_q <= '0;
        end else if (start_i) begin
            ptr_q       <= '0;
            first_q     <= 1'b1;
            got_hi_q    <= 1'b0;
            got_lo_q    <= 1'b0;
            stg_ratio_q <= ratio_cur_i;
        end else if (byte_stb_i) begin
            first_q <= 1'b0;
            ptr_q   <= (idx >= PTR_W'(MAP_BYTES)) ? PTR_W'(MAP_BYTES) : idx + PTR_W'(1);
            if (idx == PTR_W'(0)) begin
                hi_q     <= byte_data_i[HI_W-1:0];
                got_hi_q <= 1'b1;
            end
            if (idx == PTR_W'(1)) begin
                lo_q     <= byte_data_i;
                got_lo_q <= 1'b1;
            end
            if (idx == PTR_W'(CTRL_BASE))
                stg_ratio_q <= byte_data_i[RATIO_W-1:0];
        end else if (stop_i) begin
            got_hi_q <= 1'b0;
            got_lo_q <= 1'b0;
        end
    end

    for (genvar k = 0; k < CTRL_BYTES; k++) begin : g_ctrl
        logic [7:0] ctrl_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_q <= '0;
            else if (byte_stb_i && idx == PTR_W'(CTRL_BASE + k))
                ctrl_q <= byte_data_i;
        end
        assign ctrl_flat_o[k*8 +: 8] = ctrl_q;
    end

    assign commit_req_o = stop_i & got_hi_q & got_lo_q;
    assign stg_div_o    = {hi_q, lo_q};
    assign stg_ratio_o  = stg_ratio_q;

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_W'(MAP_BYTES));

    // R5
    ctrl_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_flat_o) |-> $past(byte_stb_i));

endmodule

// File: rtl/i2c_ldr_commit.sv
module i2c_ldr_commit
    import i2c_ldr_pkg::*;
#(
    parameter int DIV_W       = 15,
    parameter int RATIO_W     = 3,
    parameter int COMP_CYCLES = 10000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_req_i,
    input  logic               start_i,
    input  logic [DIV_W-1:0]   stg_div_i,
    input  logic [RATIO_W-1:0] stg_ratio_i,
    output logic [DIV_W-1:0]   div_word_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               div_load_o,
    output logic               div_abort_o,
    output logic               busy_o
);
    localparam int CNT_W = $clog2(COMP_CYCLES + 1);

    commit_state_e      state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [DIV_W-1:0]   div_prev_q;
    logic [RATIO_W-1:0] ratio_prev_q;
    logic               take, cancel;

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        cancel  = 1'b0;
        unique case (state_q)
            CM_READY: begin
                if (commit_req_i) begin
                    state_d = CM_COMPUTE;
                    take    = 1'b1;
                end
            end
            CM_COMPUTE: begin
                if (start_i) begin
                    state_d = CM_READY;
                    cancel  = 1'b1;
                end else if (cnt_q == CNT_W'(1)) begin
                    state_d = CM_READY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CM_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take)
                cnt_q <= CNT_W'(COMP_CYCLES);
            else if (state_q == CM_COMPUTE)
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_word_o   <= '0;
            ratio_o      <= '0;
            div_prev_q   <= '0;
            ratio_prev_q <= '0;
            div_load_o   <= 1'b0;
            div_abort_o  <= 1'b0;
        end else begin
            div_load_o  <= take;
            div_abort_o <= cancel;
            if (take) begin
                div_prev_q   <= div_word_o;
                ratio_prev_q <= ratio_o;
                div_word_o   <= stg_div_i;
                ratio_o      <= stg_ratio_i;
            end else if (cancel) begin
                div_word_o <= div_prev_q;
                ratio_o    <= ratio_prev_q;
            end
        end
    end

    assign busy_o = (state_q == CM_COMPUTE);

    // R6
    div_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_word_o) |-> (div_load_o || div_abort_o));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_abort_o |-> (!busy_o && $past(busy_o)));

    // R9
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !$past(start_i)) |-> ($past(cnt_q) == CNT_W'(1)));

    // R9
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_load_o |-> busy_o);

endmodule

// File: rtl/i2c_synth_loader.sv
module i2c_synth_loader
    import i2c_ldr_pkg::*;
#(
    parameter logic [4:0] ADDR_BASE   = 5'b11000,
    parameter int         COMP_CYCLES = 10000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [1:0]  addr_sel_i,
    output logic        sda_pull_o,
    output logic [14:0] div_word_o,
    output logic [2:0]  ratio_o,
    output logic [7:0]  ctrl0_o,
    output logic [7:0]  ctrl1_o,
    output logic [7:0]  ctrl2_o,
    output logic        div_load_o,
    output logic        div_abort_o,
    output logic        busy_o
);
    localparam int DIV_W   = 15;
    localparam int RATIO_W = 3;

    logic                    scl_rise, scl_fall, start_evt, stop_evt;
    logic                    byte_stb;
    logic [7:0]              byte_data;
    logic [CTRL_BYTES*8-1:0] ctrl_flat;
    logic                    commit_req;
    logic [DIV_W-1:0]        stg_div;
    logic [RATIO_W-1:0]      stg_ratio;

    i2c_ldr_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    i2c_ldr_byte_fsm #(
        .BASE_W    (5),
        .ADDR_BASE (ADDR_BASE)
    ) u_byte (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .addr_sel_i  (addr_sel_i),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_evt),
        .stop_i      (stop_evt),
        .byte_stb_o  (byte_stb),
        .byte_data_o (byte_data),
        .sda_pull_o  (sda_pull_o)
    );

    i2c_ldr_reg_map #(
        .DIV_W   (DIV_W),
        .RATIO_W (RATIO_W)
    ) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_evt),
        .stop_i       (stop_evt),
        .byte_stb_i   (byte_stb),
        .byte_data_i  (byte_data),
        .ratio_cur_i  (ratio_o),
        .ctrl_flat_o  (ctrl_flat),
        .commit_req_o (commit_req),
        .stg_div_o    (stg_div),
        .stg_ratio_o  (stg_ratio)
    );

    i2c_ldr_commit #(
        .DIV_W       (DIV_W),
        .RATIO_W     (RATIO_W),
        .COMP_CYCLES (COMP_CYCLES)
    ) u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_req_i (commit_req),
        .start_i      (start_evt),
        .stg_div_i    (stg_div),
        .stg_ratio_i  (stg_ratio),
        .div_word_o   (div_word_o),
        .ratio_o      (ratio_o),
        .div_load_o   (div_load_o),
        .div_abort_o  (div_abort_o),
        .busy_o       (busy_o)
    );

    assign ctrl0_o = ctrl_flat[7:0];
    assign ctrl1_o = ctrl_flat[15:8];
    assign ctrl2_o = ctrl_flat[23:16];

endmodule

// File: tb/i2c_synth_loader_tb.sv
`timescale 1ns/1ps
module i2c_synth_loader_tb;
    localparam int COMP = 400;
    localparam int Q    = 4;
    localparam int NV   = 7;

    // {sel, addr7, ack, nbytes, bytes[6], div, ratio, c0, c1, c2}
    localparam logic [102:0] VEC [NV] = '{
        {2'd0, 7'h60, 1'b1, 3'd5, 48'h12_34_85_A1_5C_00, 15'h1234, 3'd5, 8'h85, 8'hA1, 8'h5C},
        {2'd2, 7'h62, 1'b1, 3'd3, 48'hC3_0F_F0_00_00_00, 15'h1234, 3'd5, 8'hC3, 8'h0F, 8'hF0},
        {2'd1, 7'h61, 1'b1, 3'd2, 48'h7F_FF_00_00_00_00, 15'h7FFF, 3'd5, 8'hC3, 8'h0F, 8'hF0},
        {2'd3, 7'h60, 1'b0, 3'd2, 48'h01_02_00_00_00_00, 15'h7FFF, 3'd5, 8'hC3, 8'h0F, 8'hF0},
        {2'd3, 7'h63, 1'b1, 3'd1, 48'h05_00_00_00_00_00, 15'h7FFF, 3'd5, 8'hC3, 8'h0F, 8'hF0},
        {2'd3, 7'h63, 1'b1, 3'd6, 48'h00_01_82_11_22_99, 15'h0001, 3'd2, 8'h82, 8'h11, 8'h22},
        {2'd0, 7'h60, 1'b1, 3'd4, 48'h86_44_55_66_00_00, 15'h0001, 3'd2, 8'h86, 8'h44, 8'h55}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic sda_pull, div_load, div_abort, busy;
    logic [14:0] div_word;
    logic [2:0] ratio;
    logic [7:0] ctrl0, ctrl1, ctrl2;
    logic sda_bus;
    logic [102:0] v;
    logic ack;
    int tests = 0, fails = 0, load_cnt = 0, abort_cnt = 0, snap;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull;

    i2c_synth_loader #(.COMP_CYCLES(COMP)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .addr_sel_i(addr_sel),
        .sda_pull_o(sda_pull), .div_word_o(div_word), .ratio_o(ratio),
        .ctrl0_o(ctrl0), .ctrl1_o(ctrl1), .ctrl2_o(ctrl2),
        .div_load_o(div_load), .div_abort_o(div_abort), .busy_o(busy)
    );

    always @(posedge clk) begin
        if (rst_n && div_load) load_cnt++;
        if (rst_n && div_abort) abort_cnt++;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic i2c_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        a = ~sda_bus;
        wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        finish_run();
    end

    initial begin
        wq(5);
        // R12 reset state
        check("R12", "div", 32'(div_word), 0);
        check("R12", "ratio", 32'(ratio), 0);
        check("R12", "ctrl", {8'h0, ctrl2, ctrl1, ctrl0}, 0);
        check("R12", "busy", 32'(busy), 0);
        check("R12", "sda_pull", 32'(sda_pull), 0);
        rst_n = 1'b1;
        wq(5);

        // vector table: R1 R2 R3 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            addr_sel = v[102:101];
            i2c_start();
            i2c_byte({v[100:94], 1'b0}, ack);
            check("R1", "addr ack", 32'(ack), 32'(v[93]));
            for (int b = 0; b < int'(v[92:90]); b++) begin
                i2c_byte(v[89-8*b -: 8], ack);
                if (v[93]) check("R2", "data ack", 32'(ack), 1);
            end
            i2c_stop();
            wq(COMP + 40);
            check("R6", "div word", 32'(div_word), 32'(v[41:27]));
            check("R8", "ratio", 32'(ratio), 32'(v[26:24]));
            check("R3", "ctrl0", 32'(ctrl0), 32'(v[23:16]));
            check("R4", "ctrl1", 32'(ctrl1), 32'(v[15:8]));
            check("R4", "ctrl2", 32'(ctrl2), 32'(v[7:0]));
        end

        // R5: control bytes apply per byte, before STOP
        addr_sel = 2'd0;
        snap = load_cnt;
        i2c_start();
        i2c_byte(8'hC0, ack);
        i2c_byte(8'h81, ack);
        check("R5", "ctrl0 mid", 32'(ctrl0), 32'h81);
        i2c_byte(8'h77, ack);
        check("R5", "ctrl1 mid", 32'(ctrl1), 32'h77);
        i2c_stop();
        wq(20);
        check("R8", "ratio no pair", 32'(ratio), 2);
        check("R7", "no load", 32'(load_cnt), 32'(snap));

        // R6 staged divider, R9 busy
        i2c_start();
        i2c_byte(8'hC0, ack);
        i2c_byte(8'h03, ack);
        i2c_byte(8'h04, ack);
        check("R6", "div before stop", 32'(div_word), 32'h0001);
        i2c_byte(8'h87, ack);
        check("R5", "ctrl0 87", 32'(ctrl0), 32'h87);
        check("R8", "ratio before stop", 32'(ratio), 2);
        i2c_stop();
        wq(Q);
        check("R6", "div at stop", 32'(div_word), 32'h0304);
        check("R8", "ratio at stop", 32'(ratio), 7);
        check("R6", "load count", 32'(load_cnt), 32'(snap + 1));
        check("R9", "busy set", 32'(busy), 1);

        // R10 abort inside window
        snap = abort_cnt;
        i2c_start();
        check("R10", "abort pulse", 32'(abort_cnt), 32'(snap + 1));
        check("R10", "div restored", 32'(div_word), 32'h0001);
        check("R10", "ratio restored", 32'(ratio), 2);
        check("R10", "busy cleared", 32'(busy), 0);
        i2c_byte(8'hC0, ack);
        i2c_stop();
        wq(20);

        // R9 window expires, later START no abort
        i2c_start();
        i2c_byte(8'hC0, ack);
        i2c_byte(8'h05, ack);
        i2c_byte(8'h06, ack);
        i2c_stop();
        wq(COMP + 40);
        check("R9", "busy expired", 32'(busy), 0);
        snap = abort_cnt;
        i2c_start();
        i2c_byte(8'hC0, ack);
        i2c_stop();
        wq(20);
        check("R10", "no late abort", 32'(abort_cnt), 32'(snap));
        check("R10", "div kept", 32'(div_word), 32'h0506);

        // R1 read direction ignored
        snap = load_cnt;
        i2c_start();
        i2c_byte(8'hC1, ack);
        check("R1", "read nack", 32'(ack), 0);
        i2c_byte(8'h10, ack);
        check("R1", "ignored byte nack", 32'(ack), 0);
        i2c_byte(8'h20, ack);
        i2c_stop();
        wq(20);
        check("R1", "read no load", 32'(load_cnt), 32'(snap));
        check("R1", "read div", 32'(div_word), 32'h0506);

        // R11 repeated START resets pointer and pairing
        i2c_start();
        i2c_byte(8'hC0, ack);
        i2c_byte(8'h11, ack);
        i2c_start();
        i2c_byte(8'hC0, ack);
        i2c_byte(8'h22, ack);
        i2c_byte(8'h33, ack);
        i2c_stop();
        wq(COMP + 40);
        check("R11", "div after rstart", 32'(div_word), 32'h2233);
        check("R11", "one load", 32'(load_cnt), 32'(snap + 1));

        finish_run();
    end
endmodule